// File: doc/BRIEF.md
# DMA Channel Auto-Reload Sequencer

This block sequences one DMA channel that moves data in buffers of a programmed length. Software loads a source start address, a destination start address and a control word, sets the global enable, and starts the channel. The sequencer then issues one request per data beat on a simple request/acknowledge interface. Each acknowledged beat moves the source and destination addresses by their programmed strides.

When the last beat of a buffer completes, the working addresses and the beat count are reloaded from their programmed values and a buffer-done flag is raised. The sequencer then takes one of three paths. If the automatic bit in the programmed control word is clear, it ends the transfer. If the automatic bit is set and the buffer interrupt is enabled, it parks the channel until software writes the resume strobe. Otherwise it starts the next buffer at once. Clearing the automatic bit while a buffer is in flight makes that buffer the final one.

Registers are 32-bit words on a 4-bit word index. Index 0 is the global enable (bit 0). Index 1 is the start strobe (write bit 0). Index 2 is the resume strobe (write bit 0). Index 3 is read-only status: bit 0 active, bit 1 parked. Index 4 enables the buffer interrupt (bit 0, 1 = enabled). Index 5 holds the flags: bit 0 buffer done, bit 1 transfer done. Indices 6 and 7 are the source and destination start addresses. Index 8 is the control word. Indices 9 and 10 read back the working source and destination addresses.

The control word fields are:
- length: [15:0]
- source width: [17:16]
- destination width: [19:18]
- source mode: [21:20]
- destination mode: [23:22]
- automatic: bit 24
- source reload: bit 25
- destination reload: bit 26

Top module: `dma_reload_seq`

## Requirements
- R1: A write of 1 to bit 0 of index 1 starts an idle channel only while global enable bit 0 of index 0 is 1. At any other time the write is ignored: status stays 0 and no beat is requested.
- R2: While active and not parked, `beat_req` is 1. Each cycle with `beat_req` and `beat_ack` both high completes one beat, which uses the presented `beat_src`, `beat_dst` and `beat_width` (the source width field).
- R3: The stride per beat is 1 << width bytes, where width 0, 1 and 2 mean byte, halfword and word. For each side, a mode of 0 increments the address, 1 decrements it, and 2 or 3 leave it fixed.
- R4: A buffer holds as many beats as the length field says. A length of 0 gives one beat.
- R5: After the last beat of a buffer, buffer-done flag bit 0 of index 5 is set and the beat count is reloaded. Each working address is reloaded from its start value if its reload bit (source bit 25, destination bit 26) is 1; otherwise it continues from where it stopped.
- R6: If the automatic bit is 0 when a buffer ends, transfer-done flag bit 1 of index 5 is set and status active bit 0 of index 3 drops to 0.
- R7: If the automatic bit is 1 and the buffer interrupt is enabled when a buffer ends, status reads 3 (active and parked). No beat is requested until a resume write, which clears the parked bit and starts the next buffer.
- R8: If the automatic bit is 1 and the buffer interrupt is disabled, the next buffer's first beat is requested in the cycle right after the last beat, with no gap.
- R9: The automatic bit is taken from the programmed control word at the moment a buffer ends, so clearing it while a buffer runs makes that buffer the last.
- R10: A resume write to a channel that is not parked has no effect on status or beats.
- R11: Flags stay set until software writes 1 to the flag's bit in index 5. Writing 0 leaves a flag unchanged.
- R12: Clearing the global enable while a buffer runs ends the channel at the next acknowledged beat, sets no flag and leaves status at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write word index |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read word index |
| reg_rdata | output | 32 | Registered read data, valid one cycle after the index |
| beat_req | output | 1 | Beat request |
| beat_ack | input | 1 | Beat acknowledge; completes the beat when `beat_req` is high |
| beat_src | output | AW | Source address of the current beat |
| beat_dst | output | AW | Destination address of the current beat |
| beat_width | output | 2 | Source transfer width code |

## Verification
The bound checker watches the sequencer state on every cycle. It checks that no start happens while the channel is disabled, and that the parked state never requests a beat and is left only by a resume or an abort. It also checks that an ending buffer with automatic mode clear goes idle, that masked automatic mode requests the next beat with no gap, and that the beat count never reads zero while the channel is busy. Only the bench scenarios can show the things that depend on actual data. These are the address sequences for every mode and width, the choice between reload and continuation at a buffer end, the flag and status words seen through the register port, the effect of clearing automatic mode mid-buffer, an ignored resume, and an abort that leaves no flags behind.

// File: rtl/dma_rl_pkg.sv
package dma_rl_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_HOLD = 2'd2} seq_state_t;

  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] REG_GLB     = 4'd0;
  localparam logic [REG_AW-1:0] REG_GO      = 4'd1;
  localparam logic [REG_AW-1:0] REG_RESUME  = 4'd2;
  localparam logic [REG_AW-1:0] REG_STAT    = 4'd3;
  localparam logic [REG_AW-1:0] REG_IRQEN   = 4'd4;
  localparam logic [REG_AW-1:0] REG_FLAGS   = 4'd5;
  localparam logic [REG_AW-1:0] REG_SRC     = 4'd6;
  localparam logic [REG_AW-1:0] REG_DST     = 4'd7;
  localparam logic [REG_AW-1:0] REG_CTL     = 4'd8;
  localparam logic [REG_AW-1:0] REG_CUR_SRC = 4'd9;
  localparam logic [REG_AW-1:0] REG_CUR_DST = 4'd10;

  // control word field positions
  localparam int CTL_SW   = 16;
  localparam int CTL_DW   = 18;
  localparam int CTL_SM   = 20;
  localparam int CTL_DM   = 22;
  localparam int CTL_AUTO = 24;
  localparam int CTL_SREL = 25;
  localparam int CTL_DREL = 26;
  localparam int CTL_BITS = 27;
endpackage

// File: rtl/dma_rl_regs.sv
module dma_rl_regs
  import dma_rl_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              st_active,
  input  logic              st_hold,
  input  logic              set_buf,
  input  logic              set_xfer,
  input  logic [AW-1:0]     cur_src,
  input  logic [AW-1:0]     cur_dst,
  output logic              glb_en,
  output logic              go_req,
  output logic              resume_req,
  output logic              irq_unmask,
  output logic [AW-1:0]     src_init,
  output logic [AW-1:0]     dst_init,
  output logic [LEN_W-1:0]  len_cfg,
  output logic [1:0]        src_w,
  output logic [1:0]        dst_w,
  output logic [1:0]        src_mode,
  output logic [1:0]        dst_mode,
  output logic              auto_on,
  output logic              src_rel,
  output logic              dst_rel
);
  logic [CTL_BITS-1:0] ctl_q;
  logic                f_buf, f_xfer;
  logic                clr_wr;

  assign go_req     = wr_en && (wr_addr == REG_GO) && wr_data[0];
  assign resume_req = wr_en && (wr_addr == REG_RESUME) && wr_data[0];
  assign clr_wr     = wr_en && (wr_addr == REG_FLAGS);

  assign len_cfg  = ctl_q[LEN_W-1:0];
  assign src_w    = ctl_q[CTL_SW+:2];
  assign dst_w    = ctl_q[CTL_DW+:2];
  assign src_mode = ctl_q[CTL_SM+:2];
  assign dst_mode = ctl_q[CTL_DM+:2];
  assign auto_on  = ctl_q[CTL_AUTO];
  assign src_rel  = ctl_q[CTL_SREL];
  assign dst_rel  = ctl_q[CTL_DREL];

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en     <= 1'b0;
      irq_unmask <= 1'b0;
      src_init   <= '0;
      dst_init   <= '0;
      ctl_q      <= '0;
      f_buf      <= 1'b0;
      f_xfer     <= 1'b0;
      rd_data    <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          REG_GLB:   glb_en     <= wr_data[0];
          REG_IRQEN: irq_unmask <= wr_data[0];
          REG_SRC:   src_init   <= wr_data[AW-1:0];
          REG_DST:   dst_init   <= wr_data[AW-1:0];
          REG_CTL:   ctl_q      <= wr_data[CTL_BITS-1:0];
          default: ;
        endcase
      end
      // a new event wins over a clear in the same cycle
      f_buf  <= set_buf  | (f_buf  & ~(clr_wr & wr_data[0]));
      f_xfer <= set_xfer | (f_xfer & ~(clr_wr & wr_data[1]));
      case (rd_addr)
        REG_GLB:     rd_data <= DW'(glb_en);
        REG_STAT:    rd_data <= DW'({st_hold, st_active});
        REG_IRQEN:   rd_data <= DW'(irq_unmask);
        REG_FLAGS:   rd_data <= DW'({f_xfer, f_buf});
        REG_SRC:     rd_data <= DW'(src_init);
        REG_DST:     rd_data <= DW'(dst_init);
        REG_CTL:     rd_data <= DW'(ctl_q);
        REG_CUR_SRC: rd_data <= DW'(cur_src);
        REG_CUR_DST: rd_data <= DW'(cur_dst);
        default:     rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_rl_addr.sv
module dma_rl_addr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] init,
  input  logic          adv,
  input  logic          rel,
  input  logic [1:0]    width,
  input  logic [1:0]    mode,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] stride, stepped;

  assign stride = AW'(1) << width;

  always_comb begin
    case (mode)
      2'd0:    stepped = addr + stride;
      2'd1:    stepped = addr - stride;
      default: stepped = addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= init;
    else if (adv)  addr <= rel ? init : stepped;
  end
endmodule

// File: rtl/dma_rl_seq.sv
module dma_rl_seq
  import dma_rl_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             glb_en,
  input  logic             go_req,
  input  logic             resume_req,
  input  logic             beat_ack,
  input  logic             auto_on,
  input  logic             irq_unmask,
  input  logic [LEN_W-1:0] len_cfg,
  output seq_state_t       state,
  output logic             load,
  output logic             adv,
  output logic             boundary,
  output logic             set_buf,
  output logic             set_xfer,
  output logic [LEN_W-1:0] beats_left
);
  logic [LEN_W-1:0] eff_len;
  seq_state_t       nxt;

  assign eff_len  = (len_cfg == '0) ? LEN_W'(1) : len_cfg;
  assign load     = go_req && glb_en && (state == ST_IDLE);
  assign adv      = (state == ST_RUN) && beat_ack;
  assign boundary = adv && (beats_left == LEN_W'(1));
  assign set_buf  = boundary && glb_en;
  assign set_xfer = boundary && glb_en && !auto_on;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (load) nxt = ST_RUN;
      ST_RUN: begin
        if (adv && !glb_en)  nxt = ST_IDLE;
        else if (boundary) begin
          if (!auto_on)        nxt = ST_IDLE;
          else if (irq_unmask) nxt = ST_HOLD;
          else                 nxt = ST_RUN;
        end
      end
      ST_HOLD: begin
        if (!glb_en)         nxt = ST_IDLE;
        else if (resume_req) nxt = ST_RUN;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      beats_left <= '0;
    end else begin
      state <= nxt;
      if (load)     beats_left <= eff_len;
      else if (adv) beats_left <= boundary ? eff_len : beats_left - LEN_W'(1);
    end
  end
endmodule

// File: rtl/dma_reload_seq.sv
module dma_reload_seq
  import dma_rl_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [DW-1:0]     reg_rdata,
  output logic              beat_req,
  input  logic              beat_ack,
  output logic [AW-1:0]     beat_src,
  output logic [AW-1:0]     beat_dst,
  output logic [1:0]        beat_width
);
  seq_state_t       st;
  logic             glb_en, go_req, resume_req, irq_unmask;
  logic [AW-1:0]    src_init, dst_init;
  logic [LEN_W-1:0] len_cfg, beats_left;
  logic [1:0]       src_w, dst_w, src_mode, dst_mode;
  logic             auto_on, src_rel, dst_rel;
  logic             load, adv, boundary, set_buf, set_xfer;

  dma_rl_regs #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_addr(reg_waddr), .wr_data(reg_wdata),
    .rd_addr(reg_raddr), .rd_data(reg_rdata),
    .st_active(st != ST_IDLE), .st_hold(st == ST_HOLD),
    .set_buf(set_buf), .set_xfer(set_xfer), .cur_src(beat_src), .cur_dst(beat_dst),
    .glb_en(glb_en), .go_req(go_req), .resume_req(resume_req), .irq_unmask(irq_unmask),
    .src_init(src_init), .dst_init(dst_init), .len_cfg(len_cfg),
    .src_w(src_w), .dst_w(dst_w), .src_mode(src_mode), .dst_mode(dst_mode),
    .auto_on(auto_on), .src_rel(src_rel), .dst_rel(dst_rel)
  );

  dma_rl_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .glb_en(glb_en), .go_req(go_req), .resume_req(resume_req),
    .beat_ack(beat_ack), .auto_on(auto_on), .irq_unmask(irq_unmask), .len_cfg(len_cfg),
    .state(st), .load(load), .adv(adv), .boundary(boundary),
    .set_buf(set_buf), .set_xfer(set_xfer), .beats_left(beats_left)
  );

  dma_rl_addr #(.AW(AW)) u_src (
    .clk(clk), .rst(rst), .load(load), .init(src_init), .adv(adv),
    .rel(boundary && src_rel), .width(src_w), .mode(src_mode), .addr(beat_src)
  );

  dma_rl_addr #(.AW(AW)) u_dst (
    .clk(clk), .rst(rst), .load(load), .init(dst_init), .adv(adv),
    .rel(boundary && dst_rel), .width(dst_w), .mode(dst_mode), .addr(beat_dst)
  );

  assign beat_req   = (st == ST_RUN);
  assign beat_width = src_w;
endmodule

// File: rtl/dma_reload_seq_chk.sv
module dma_reload_seq_chk
  import dma_rl_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input seq_state_t       st,
  input logic             glb_en,
  input logic             beat_req,
  input logic             beat_ack,
  input logic             resume_req,
  input logic             auto_on,
  input logic             irq_unmask,
  input logic [LEN_W-1:0] beats_left
);
  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !glb_en) |=> (st == ST_IDLE));

  a_r7_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD) |-> !beat_req);

  a_r7_hold_waits: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD && !resume_req && glb_en) |=> (st == ST_HOLD));

  a_r6_last_ends: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && beat_ack && beats_left == LEN_W'(1) && !auto_on && glb_en)
    |=> (st == ST_IDLE));

  a_r8_no_gap: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && beat_ack && beats_left == LEN_W'(1) && auto_on && !irq_unmask && glb_en)
    |=> beat_req);

  a_r4_count_live: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |-> (beats_left != '0));
endmodule

bind dma_reload_seq dma_reload_seq_chk #(.LEN_W(LEN_W)) i_chk (
  .clk(clk), .rst(rst), .st(st), .glb_en(glb_en), .beat_req(beat_req),
  .beat_ack(beat_ack), .resume_req(resume_req), .auto_on(auto_on),
  .irq_unmask(irq_unmask), .beats_left(beats_left)
);

// File: tb/test_dma_reload_seq.sv
module test_dma_reload_seq;
  localparam int AW = 32;
  localparam int DW = 32;

  typedef struct {
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    logic [1:0]    w;
  } beat_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [3:0]    reg_waddr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [3:0]    reg_raddr = '0;
  logic [DW-1:0] reg_rdata;
  logic          beat_req;
  logic          ack_en = 1'b0;
  logic          beat_ack;
  logic [AW-1:0] beat_src, beat_dst;
  logic [1:0]    beat_width;

  int total = 0;
  int bad = 0;
  int beats_seen = 0;
  bit finished = 0;
  beat_t expq[$];

  assign beat_ack = ack_en;

  always #10 clk = ~clk;

  dma_reload_seq i_dma_reload_seq (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .beat_req(beat_req), .beat_ack(beat_ack),
    .beat_src(beat_src), .beat_dst(beat_dst), .beat_width(beat_width)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && beat_req && beat_ack) begin
      beats_seen++;
      if (expq.size() == 0) begin
        check(0, "R2 unexpected beat", beat_src, 0);
      end else begin
        beat_t e;
        e = expq.pop_front();
        check(beat_src == e.src && beat_dst == e.dst && beat_width == e.w,
              "R2/R3 beat src,dst,width", {beat_src, beat_dst}, {e.src, e.dst});
      end
    end
  end

  function automatic logic [AW-1:0] stp(input logic [AW-1:0] a, input int w, input int m);
    if (m == 0) return a + (AW'(1) << w);
    if (m == 1) return a - (AW'(1) << w);
    return a;
  endfunction

  // driver side: push n expected beats
  task automatic push_beats(input logic [AW-1:0] s0, input logic [AW-1:0] d0, input int n,
                            input int sw, input int dw, input int sm, input int dm);
    logic [AW-1:0] s, d;
    s = s0; d = d0;
    for (int k = 0; k < n; k++) begin
      beat_t e;
      e.src = s; e.dst = d; e.w = 2'(sw);
      expq.push_back(e);
      s = stp(s, sw, sm);
      d = stp(d, dw, dm);
    end
  endtask

  function automatic logic [31:0] ctlw(input int len, input int sw, input int dw, input int sm,
                                       input int dm, input bit au, input bit sr, input bit dr);
    return 32'(len & 16'hffff) | (32'(sw) << 16) | (32'(dw) << 18) | (32'(sm) << 20) |
           (32'(dm) << 22) | (32'(au) << 24) | (32'(sr) << 25) | (32'(dr) << 26);
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_raddr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic run_beats(input int n);
    @(negedge clk);
    ack_en = 1'b1;
    repeat (n) @(negedge clk);
    ack_en = 1'b0;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    check(v == exp, tag, v, exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    check(beat_req == 1'b0, "R2 reset req", beat_req, 0);
    expect_reg(4'd3, 0, "R6 reset status");
    expect_reg(4'd5, 0, "R11 reset flags");

    // R1: start while globally disabled is ignored
    wr(4'd6, 32'h1000);
    wr(4'd7, 32'h2000);
    wr(4'd8, ctlw(4, 2, 0, 0, 0, 0, 1, 1));
    wr(4'd1, 1);
    repeat (3) @(negedge clk);
    check(beat_req == 1'b0, "R1 no req when disabled", beat_req, 0);
    expect_reg(4'd3, 0, "R1 status when disabled");

    // single buffer, word source inc, byte destination inc
    wr(4'd0, 1);
    push_beats(32'h1000, 32'h2000, 4, 2, 0, 0, 0);
    wr(4'd1, 1);
    expect_reg(4'd3, 1, "R1 started / R6 active");
    run_beats(8);
    check(expq.size() == 0, "R4 all beats of buffer", expq.size(), 0);
    expect_reg(4'd3, 0, "R6 active clears at end");
    expect_reg(4'd5, 3, "R5/R6 flags set");
    expect_reg(4'd9, 32'h1000, "R5 src reloaded");
    expect_reg(4'd10, 32'h2000, "R5 dst reloaded");

    // R11 write-one-to-clear, zero leaves flag
    wr(4'd5, 0);
    expect_reg(4'd5, 3, "R11 write 0 keeps flags");
    wr(4'd5, 1);
    expect_reg(4'd5, 2, "R11 clear buffer flag");
    wr(4'd5, 2);
    expect_reg(4'd5, 0, "R11 clear transfer flag");

    // R3 halfword decrement source, word fixed destination
    wr(4'd6, 32'h3000);
    wr(4'd7, 32'h4000);
    wr(4'd8, ctlw(3, 1, 2, 1, 2, 0, 1, 1));
    push_beats(32'h3000, 32'h4000, 3, 1, 2, 1, 2);
    wr(4'd1, 1);
    run_beats(6);
    check(expq.size() == 0, "R3 dec/fixed beats done", expq.size(), 0);
    expect_reg(4'd5, 3, "R6 flags after dec buffer");
    wr(4'd5, 3);

    // R4 zero length gives one beat
    wr(4'd8, ctlw(0, 0, 0, 0, 0, 0, 1, 1));
    push_beats(32'h3000, 32'h4000, 1, 0, 0, 0, 0);
    base = beats_seen;
    wr(4'd1, 1);
    run_beats(4);
    check(beats_seen - base == 1, "R4 zero length one beat", beats_seen - base, 1);
    expect_reg(4'd3, 0, "R4 idle after one beat");
    wr(4'd5, 3);

    // R7 automatic with interrupt enabled parks after buffer
    wr(4'd4, 1);
    wr(4'd6, 32'h8000);
    wr(4'd7, 32'h9000);
    wr(4'd8, ctlw(2, 2, 2, 0, 0, 1, 1, 1));
    push_beats(32'h8000, 32'h9000, 2, 2, 2, 0, 0);
    base = beats_seen;
    wr(4'd1, 1);
    run_beats(6);
    check(beats_seen - base == 2, "R7 stops after buffer", beats_seen - base, 2);
    expect_reg(4'd3, 3, "R7 parked status");
    expect_reg(4'd5, 1, "R5 buffer flag only");
    check(beat_req == 1'b0, "R7 no req while parked", beat_req, 0);
    // R9 clear automatic while parked; next buffer is last
    wr(4'd8, ctlw(2, 2, 2, 0, 0, 0, 1, 1));
    push_beats(32'h8000, 32'h9000, 2, 2, 2, 0, 0);
    wr(4'd2, 1);
    expect_reg(4'd3, 1, "R7 resume clears parked");
    run_beats(6);
    check(beats_seen - base == 4, "R9 second buffer last", beats_seen - base, 4);
    expect_reg(4'd3, 0, "R9 idle after last");
    expect_reg(4'd5, 3, "R9 transfer flag");
    wr(4'd5, 3);

    // R10 resume when idle or running has no effect
    base = beats_seen;
    wr(4'd2, 1);
    repeat (2) @(negedge clk);
    check(beat_req == 1'b0, "R10 resume idle no req", beat_req, 0);
    expect_reg(4'd3, 0, "R10 resume idle status");
    wr(4'd8, ctlw(4, 2, 2, 0, 0, 0, 1, 1));
    push_beats(32'h8000, 32'h9000, 4, 2, 2, 0, 0);
    wr(4'd1, 1);
    run_beats(1);
    wr(4'd2, 1);
    expect_reg(4'd3, 1, "R10 resume while running");
    run_beats(8);
    check(beats_seen - base == 4, "R10 no extra beats", beats_seen - base, 4);
    wr(4'd5, 3);

    // R8 masked automatic, source continues, destination reloads
    wr(4'd4, 0);
    wr(4'd6, 32'h5000);
    wr(4'd7, 32'h6000);
    wr(4'd8, ctlw(2, 2, 2, 0, 0, 1, 0, 1));
    push_beats(32'h5000, 32'h6000, 2, 2, 2, 0, 0);
    push_beats(32'h5008, 32'h6000, 2, 2, 2, 0, 0);
    push_beats(32'h5010, 32'h6000, 2, 2, 2, 0, 0);
    base = beats_seen;
    wr(4'd1, 1);
    run_beats(5);
    check(beats_seen - base == 5, "R8 back to back buffers", beats_seen - base, 5);
    expect_reg(4'd3, 1, "R8 not parked");
    wr(4'd8, ctlw(2, 2, 2, 0, 0, 0, 0, 1));
    run_beats(4);
    check(beats_seen - base == 6, "R9 cleared mid buffer ends", beats_seen - base, 6);
    expect_reg(4'd3, 0, "R9 idle");
    expect_reg(4'd9, 32'h5018, "R5 src continues without reload");
    expect_reg(4'd10, 32'h6000, "R5 dst reloaded");
    wr(4'd5, 3);

    // R12 abort by clearing global enable
    wr(4'd6, 32'hA000);
    wr(4'd7, 32'hB000);
    wr(4'd8, ctlw(8, 0, 0, 0, 0, 0, 1, 1));
    push_beats(32'hA000, 32'hB000, 3, 0, 0, 0, 0);
    base = beats_seen;
    wr(4'd1, 1);
    run_beats(2);
    wr(4'd0, 0);
    run_beats(4);
    check(beats_seen - base == 3, "R12 ends at next beat", beats_seen - base, 3);
    expect_reg(4'd3, 0, "R12 status cleared");
    expect_reg(4'd5, 0, "R12 no flags");

    check(expq.size() == 0, "R2 scoreboard drained", expq.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule